// File: doc/BRIEF.md
# Debug Instruction Stream Tracker

This block follows the byte stream of a two-wire debug port after the serial framing layer has been stripped. Its input is one validated byte at a time, plus a break event. The first byte of each instruction is an opcode. From the opcode's size and selector fields the block works out how many operand items the programmer sends and how many data items the device returns. It then assembles each multi-byte item into one wide value and reports it with its width and its direction.

A REPEAT instruction leaves behind a count. That count extends the next indirect load or indirect store to count+1 data items. A break abandons whatever instruction is in progress and discards the count. The byte after a break is taken as a fresh opcode.

The block only reports what the stream means. It performs no memory access and does not interpret addresses.

Top module: `dit_tracker`

## Requirements
- R1: Reset clears every strobe. An accepted byte that arrives while no instruction is open is an opcode. One cycle later `op_valid` pulses with `op_code` = byte[7:5], `op_sel` = byte[3:2], `op_addr_bytes` = byte[3:2]+1, `op_data_bytes` = byte[1:0]+1 and `op_reg` = byte[3:0]. Opcode values: 0 direct load, 1 indirect load, 2 direct store, 3 indirect store, 4 control load, 5 repeat, 6 control store, 7 key.
- R2: A direct load (0) takes one write item of byte[3:2]+1 bytes and then one read item of byte[1:0]+1 bytes.
- R3: A direct store (2) takes two write items: first byte[3:2]+1 bytes, then byte[1:0]+1 bytes.
- R4: A control load (4) is one 1-byte read item. A control store (6) is one 1-byte write item.
- R5: A key instruction (7) is one 8-byte write item. A repeat instruction (5) is one write item of byte[1:0]+1 bytes, and the value of that item becomes the repeat count.
- R6: With a repeat count N, the next indirect load (1) or indirect store (3) carries N+1 items of byte[1:0]+1 bytes each, and that instruction clears the count. Any other instruction leaves the count unchanged.
- R7: Items are assembled least significant byte first. `item_valid` pulses one cycle after the last byte of an item. In that cycle `item_len` holds the byte count and `item_dir` holds the direction (0 = programmer write, 1 = device read). All write items of an instruction come before its read items.
- R8: `insn_done` pulses one cycle after the `item_valid` of an instruction's final item.
- R9: `brk` aborts the open instruction: no further items are reported for it, the repeat count is cleared, and `insn_done` pulses in the next cycle if an instruction was open. A byte presented in the same cycle as `brk` is dropped. The next accepted byte is an opcode.
- R10: `op_valid` and `item_valid` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| byte_valid | input | 1 | A validated byte is present |
| byte_data | input | 8 | The byte |
| brk | input | 1 | Break event on the link |
| op_valid | output | 1 | Opcode strobe |
| op_code | output | 3 | Opcode, byte[7:5] |
| op_sel | output | 2 | Raw byte[3:2] (pointer mode for indirect ops) |
| op_addr_bytes | output | 3 | Address size in bytes |
| op_data_bytes | output | 3 | Data size in bytes |
| op_reg | output | 4 | Control register number, byte[3:0] |
| item_valid | output | 1 | Item strobe |
| item_data | output | 64 | Assembled item, LSB-first |
| item_len | output | 4 | Item size in bytes |
| item_dir | output | 1 | 0 write by programmer, 1 read from device |
| insn_done | output | 1 | Instruction finished or aborted |

## Verification
The opcode strobe and the item strobe both appear exactly one cycle after the edge that accepted the causing byte. The completion pulse comes one cycle after the final item strobe, or one cycle after a break that hits an open instruction. The reference model in the bench runs on the same rising edge as the design and produces the values due after that edge. The bench compares every output at the following falling edge, so each result is checked in the exact cycle the requirements place it, never earlier and never later.

// File: rtl/dit_pkg.sv
package dit_pkg;
  localparam int LEN_BITS  = 4;
  localparam int KEY_BYTES = 8;

  typedef enum logic [2:0] {
    OP_LOAD_DIR  = 3'd0,
    OP_LOAD_IND  = 3'd1,
    OP_STORE_DIR = 3'd2,
    OP_STORE_IND = 3'd3,
    OP_LOAD_CS   = 3'd4,
    OP_REPEAT    = 3'd5,
    OP_STORE_CS  = 3'd6,
    OP_KEY       = 3'd7
  } dit_op_e;

  typedef struct packed {
    logic [1:0]          wr_items;
    logic                rd_items;
    logic [LEN_BITS-1:0] wr_first_len;
    logic [LEN_BITS-1:0] wr_rest_len;
    logic [LEN_BITS-1:0] rd_len;
    logic                rep_ext;
  } dit_plan_t;
endpackage

// File: rtl/dit_decode.sv
module dit_decode
  import dit_pkg::*;
(
  input  logic [7:0] op_byte,
  output dit_plan_t  plan
);
  logic [LEN_BITS-1:0] a_len;
  logic [LEN_BITS-1:0] d_len;

  always_comb begin
    a_len = LEN_BITS'(op_byte[3:2]) + LEN_BITS'(1);
    d_len = LEN_BITS'(op_byte[1:0]) + LEN_BITS'(1);
    plan  = '0;
    unique case (dit_op_e'(op_byte[7:5]))
      OP_LOAD_DIR: begin
        plan.wr_items = 2'd1; plan.wr_first_len = a_len;
        plan.rd_items = 1'b1; plan.rd_len = d_len;
      end
      OP_LOAD_IND: begin
        plan.rd_items = 1'b1; plan.rd_len = d_len; plan.rep_ext = 1'b1;
      end
      OP_STORE_DIR: begin
        plan.wr_items = 2'd2; plan.wr_first_len = a_len; plan.wr_rest_len = d_len;
      end
      OP_STORE_IND: begin
        plan.wr_items = 2'd1; plan.wr_first_len = d_len; plan.wr_rest_len = d_len;
        plan.rep_ext = 1'b1;
      end
      OP_LOAD_CS: begin
        plan.rd_items = 1'b1; plan.rd_len = LEN_BITS'(1);
      end
      OP_REPEAT: begin
        plan.wr_items = 2'd1; plan.wr_first_len = d_len;
      end
      OP_STORE_CS: begin
        plan.wr_items = 2'd1; plan.wr_first_len = LEN_BITS'(1);
      end
      default: begin
        plan.wr_items = 2'd1; plan.wr_first_len = LEN_BITS'(KEY_BYTES);
      end
    endcase
  end
endmodule

// File: rtl/dit_assemble.sv
module dit_assemble #(
  parameter int MAX_BYTES = 8,
  localparam int POS_W  = $clog2(MAX_BYTES),
  localparam int ITEM_W = 8 * MAX_BYTES
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              load,
  input  logic [POS_W-1:0]  pos,
  input  logic [7:0]        din,
  output logic [ITEM_W-1:0] merged
);
  logic [ITEM_W-1:0] acc;

  for (genvar i = 0; i < MAX_BYTES; i++) begin : g_lane
    assign merged[8*i +: 8] = (load && pos == POS_W'(i)) ? din : acc[8*i +: 8];
  end

  always_ff @(posedge clk) begin
    if (rst || clr) acc <= '0;
    else if (load)  acc <= merged;
  end
endmodule

// File: rtl/dit_tracker.sv
module dit_tracker
  import dit_pkg::*;
#(
  parameter int REP_W          = 32,
  parameter int MAX_ITEM_BYTES = 8,
  localparam int ITEM_W = 8 * MAX_ITEM_BYTES,
  localparam int POS_W  = $clog2(MAX_ITEM_BYTES),
  localparam int CNT_W  = REP_W + 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                byte_valid,
  input  logic [7:0]          byte_data,
  input  logic                brk,
  output logic                op_valid,
  output logic [2:0]          op_code,
  output logic [1:0]          op_sel,
  output logic [2:0]          op_addr_bytes,
  output logic [2:0]          op_data_bytes,
  output logic [3:0]          op_reg,
  output logic                item_valid,
  output logic [ITEM_W-1:0]   item_data,
  output logic [LEN_BITS-1:0] item_len,
  output logic                item_dir,
  output logic                insn_done
);
  dit_plan_t           plan;
  logic [ITEM_W-1:0]   merged;
  logic                busy, in_rd, fin;
  logic [CNT_W-1:0]    wr_left, rd_left, rep_ext_cnt;
  logic [LEN_BITS-1:0] rest_len, rd_len_q, cur_len;
  logic [POS_W-1:0]    pos;
  logic [REP_W-1:0]    rep_cnt;
  dit_op_e             cur_op;
  logic                take, is_op, is_dat, item_end;

  assign take        = byte_valid && !brk;
  assign is_op       = take && !busy;
  assign is_dat      = take && busy;
  assign item_end    = is_dat && ((LEN_BITS'(pos) + LEN_BITS'(1)) == cur_len);
  assign rep_ext_cnt = CNT_W'(rep_cnt) + CNT_W'(1);

  dit_decode u_dec (.op_byte(byte_data), .plan(plan));

  dit_assemble #(.MAX_BYTES(MAX_ITEM_BYTES)) u_asm (
    .clk(clk), .rst(rst), .clr(brk || is_op || item_end), .load(is_dat),
    .pos(pos), .din(byte_data), .merged(merged)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      op_valid <= 1'b0; op_code <= '0; op_sel <= '0; op_addr_bytes <= '0;
      op_data_bytes <= '0; op_reg <= '0;
      item_valid <= 1'b0; item_data <= '0; item_len <= '0; item_dir <= 1'b0;
      insn_done <= 1'b0; fin <= 1'b0;
      busy <= 1'b0; in_rd <= 1'b0; wr_left <= '0; rd_left <= '0;
      rest_len <= '0; rd_len_q <= '0; cur_len <= '0; pos <= '0;
      rep_cnt <= '0; cur_op <= OP_LOAD_DIR;
    end else begin
      op_valid   <= 1'b0;
      item_valid <= 1'b0;
      fin        <= 1'b0;
      insn_done  <= fin || (brk && busy);
      if (brk) begin
        busy    <= 1'b0;
        rep_cnt <= '0;
        pos     <= '0;
      end else if (is_op) begin
        op_valid      <= 1'b1;
        op_code       <= byte_data[7:5];
        op_sel        <= byte_data[3:2];
        op_addr_bytes <= 3'(byte_data[3:2]) + 3'd1;
        op_data_bytes <= 3'(byte_data[1:0]) + 3'd1;
        op_reg        <= byte_data[3:0];
        cur_op        <= dit_op_e'(byte_data[7:5]);
        busy          <= 1'b1;
        pos           <= '0;
        in_rd         <= (plan.wr_items == 2'd0);
        wr_left       <= (plan.rep_ext && plan.wr_items != 2'd0) ? rep_ext_cnt
                                                                 : CNT_W'(plan.wr_items);
        rd_left       <= (plan.rep_ext && plan.rd_items) ? rep_ext_cnt
                                                         : CNT_W'(plan.rd_items);
        rest_len      <= plan.wr_rest_len;
        rd_len_q      <= plan.rd_len;
        cur_len       <= (plan.wr_items != 2'd0) ? plan.wr_first_len : plan.rd_len;
        if (plan.rep_ext) rep_cnt <= '0;
      end else if (is_dat) begin
        pos <= pos + POS_W'(1);
        if (item_end) begin
          item_valid <= 1'b1;
          item_data  <= merged;
          item_len   <= cur_len;
          item_dir   <= in_rd;
          pos        <= '0;
          if (cur_op == OP_REPEAT) rep_cnt <= merged[REP_W-1:0];
          if (!in_rd) begin
            wr_left <= wr_left - CNT_W'(1);
            if (wr_left != CNT_W'(1)) begin
              cur_len <= rest_len;
            end else if (rd_left != '0) begin
              in_rd   <= 1'b1;
              cur_len <= rd_len_q;
            end else begin
              busy <= 1'b0;
              fin  <= 1'b1;
            end
          end else begin
            rd_left <= rd_left - CNT_W'(1);
            if (rd_left == CNT_W'(1)) begin
              busy <= 1'b0;
              fin  <= 1'b1;
            end
          end
        end
      end
    end
  end
endmodule

// File: rtl/dit_tracker_chk.sv
module dit_tracker_chk (
  input logic       clk,
  input logic       rst,
  input logic       byte_valid,
  input logic       brk,
  input logic       op_valid,
  input logic       item_valid,
  input logic [3:0] item_len,
  input logic       insn_done
);
  p_op_cause_r1: assert property (@(posedge clk) disable iff (rst)
    op_valid |-> $past(byte_valid && !brk));

  p_item_cause_r7: assert property (@(posedge clk) disable iff (rst)
    item_valid |-> $past(byte_valid && !brk));

  p_item_len_r7: assert property (@(posedge clk) disable iff (rst)
    item_valid |-> (item_len >= 4'd1 && item_len <= 4'd8));

  p_done_cause_r8: assert property (@(posedge clk) disable iff (rst)
    insn_done |-> ($past(item_valid) || $past(brk)));

  p_brk_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    brk |=> (!op_valid && !item_valid));

  p_excl_r10: assert property (@(posedge clk) disable iff (rst)
    !(op_valid && item_valid));
endmodule

bind dit_tracker dit_tracker_chk u_chk (
  .clk(clk), .rst(rst), .byte_valid(byte_valid), .brk(brk),
  .op_valid(op_valid), .item_valid(item_valid), .item_len(item_len),
  .insn_done(insn_done)
);

// File: tb/dit_tracker_tb.sv
module dit_tracker_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        byte_valid = 1'b0;
  logic [7:0]  byte_data = 8'h00;
  logic        brk = 1'b0;
  logic        op_valid, item_valid, item_dir, insn_done;
  logic [2:0]  op_code, op_addr_bytes, op_data_bytes;
  logic [1:0]  op_sel;
  logic [3:0]  op_reg, item_len;
  logic [63:0] item_data;

  always #(CLK_PERIOD/2) clk = ~clk;

  dit_tracker u_dut (
    .clk(clk), .rst(rst), .byte_valid(byte_valid), .byte_data(byte_data), .brk(brk),
    .op_valid(op_valid), .op_code(op_code), .op_sel(op_sel),
    .op_addr_bytes(op_addr_bytes), .op_data_bytes(op_data_bytes), .op_reg(op_reg),
    .item_valid(item_valid), .item_data(item_data), .item_len(item_len),
    .item_dir(item_dir), .insn_done(insn_done)
  );

  int    n_vec = 0;
  int    n_bad = 0;
  string tag = "R1";

  // reference model state
  bit             m_busy = 0, m_pend = 0;
  int             m_lens[$];
  bit             m_dirs[$];
  int             m_op = 0, m_pos = 0;
  longint unsigned m_acc = 0, m_rep = 0;
  // expected outputs
  bit             e_opv = 0, e_itv = 0, e_done = 0, e_dir = 0;
  int             e_op = 0, e_sel = 0, e_ab = 0, e_db = 0, e_reg = 0, e_len = 0;
  longint unsigned e_data = 0;

  always @(posedge clk) begin
    if (rst) begin
      m_busy = 0; m_pend = 0; m_lens.delete(); m_dirs.delete();
      m_pos = 0; m_acc = 0; m_rep = 0;
      e_opv = 0; e_itv = 0; e_done = 0;
    end else begin
      e_opv = 0; e_itv = 0;
      e_done = m_pend; m_pend = 0;
      if (brk) begin
        if (m_busy) e_done = 1;
        m_busy = 0; m_lens.delete(); m_dirs.delete();
        m_rep = 0; m_acc = 0; m_pos = 0;
      end else if (byte_valid) begin
        if (!m_busy) begin
          int a, d;
          m_op = int'(byte_data[7:5]);
          a = int'(byte_data[3:2]) + 1;
          d = int'(byte_data[1:0]) + 1;
          e_opv = 1; e_op = m_op; e_sel = int'(byte_data[3:2]);
          e_ab = a; e_db = d; e_reg = int'(byte_data[3:0]);
          case (m_op)
            0: begin m_lens.push_back(a); m_dirs.push_back(0);
                     m_lens.push_back(d); m_dirs.push_back(1); end
            1: begin for (int k = 0; k <= int'(m_rep); k++) begin
                       m_lens.push_back(d); m_dirs.push_back(1); end
                     m_rep = 0; end
            2: begin m_lens.push_back(a); m_dirs.push_back(0);
                     m_lens.push_back(d); m_dirs.push_back(0); end
            3: begin for (int k = 0; k <= int'(m_rep); k++) begin
                       m_lens.push_back(d); m_dirs.push_back(0); end
                     m_rep = 0; end
            4: begin m_lens.push_back(1); m_dirs.push_back(1); end
            5: begin m_lens.push_back(d); m_dirs.push_back(0); end
            6: begin m_lens.push_back(1); m_dirs.push_back(0); end
            default: begin m_lens.push_back(8); m_dirs.push_back(0); end
          endcase
          m_busy = 1; m_acc = 0; m_pos = 0;
        end else begin
          m_acc = m_acc | (64'(byte_data) << (8 * m_pos));
          m_pos++;
          if (m_pos == m_lens[0]) begin
            e_itv = 1; e_data = m_acc; e_len = m_lens[0]; e_dir = m_dirs[0];
            void'(m_lens.pop_front()); void'(m_dirs.pop_front());
            if (m_op == 5) m_rep = m_acc & 64'hFFFF_FFFF;
            m_acc = 0; m_pos = 0;
            if (m_lens.size() == 0) begin m_busy = 0; m_pend = 1; end
          end
        end
      end
    end
  end

  task automatic chk(input string what, input longint unsigned act, input longint unsigned exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    chk("op_valid", 64'(op_valid), 64'(e_opv));
    chk("item_valid", 64'(item_valid), 64'(e_itv));
    chk("insn_done", 64'(insn_done), 64'(e_done));
    if (op_valid && item_valid) begin
      n_bad++;
      $display("FAIL R10 both strobes high actual=1 expected=0");
    end
    if (e_opv) begin
      chk("op_code", 64'(op_code), 64'(e_op));
      chk("op_sel", 64'(op_sel), 64'(e_sel));
      chk("op_addr_bytes", 64'(op_addr_bytes), 64'(e_ab));
      chk("op_data_bytes", 64'(op_data_bytes), 64'(e_db));
      chk("op_reg", 64'(op_reg), 64'(e_reg));
    end
    if (e_itv) begin
      chk("item_data", item_data, e_data);
      chk("item_len", 64'(item_len), 64'(e_len));
      chk("item_dir", 64'(item_dir), 64'(e_dir));
    end
  end

  task automatic send(input logic [7:0] b);
    byte_valid = 1'b1; byte_data = b;
    @(negedge clk);
    byte_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_brk(input bit with_byte);
    brk = 1'b1; byte_valid = with_byte; byte_data = 8'hA0;
    @(negedge clk);
    brk = 1'b0; byte_valid = 1'b0;
  endtask

  task automatic phase(input string t);
    idle(3);
    tag = t;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired (R8 completion never reached)");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    tag = "R1";                       // reset state
    idle(4);
    rst = 1'b0;
    idle(2);
    phase("R2");                      // direct load: 2-byte addr write, 2-byte read
    send(8'h05); send(8'h34); send(8'h12); idle(1); send(8'hCD); send(8'hAB);
    phase("R3");                      // direct store: 4-byte addr, 1-byte data
    send(8'h4C); send(8'h11); send(8'h22); send(8'h33); send(8'h44); send(8'h99);
    phase("R4");                      // control load reg 2, control store reg 1
    send(8'h82); send(8'h5A);
    send(8'hC1); send(8'hA5);
    phase("R5");                      // key: 8-byte write
    send(8'hE0);
    for (int i = 0; i < 8; i++) send(8'(8'h10 + i));
    phase("R6");                      // repeat 3, unrelated insn, then indirect load x4
    send(8'hA0); send(8'h03);
    send(8'h82); send(8'h77);
    send(8'h21);
    for (int i = 0; i < 8; i++) send(8'(8'hB0 + i));
    send(8'h20); send(8'h42);         // count cleared: single item
    send(8'hA1); send(8'h02); send(8'h00);
    send(8'h64); send(8'h01); send(8'h02); send(8'h03);
    phase("R7");                      // 3-byte and 4-byte items, LSB first
    send(8'h0E); send(8'h01); send(8'h02); send(8'h03); send(8'h04);
    send(8'hAA); send(8'hBB); send(8'hCC);
    phase("R9");                      // break mid direct store, then control load
    send(8'h4D); send(8'h01); pulse_brk(1'b0);
    send(8'h83); send(8'h3C);
    send(8'hA0); send(8'h02); pulse_brk(1'b0);   // count dropped by break
    send(8'h20); send(8'h55);
    send(8'h21); send(8'h01); pulse_brk(1'b1);   // byte with break dropped
    send(8'hC0); send(8'h66);
    pulse_brk(1'b0);                  // break while idle: no completion
    phase("R8");                      // back-to-back instructions
    send(8'hC2); send(8'h01); send(8'h80); send(8'h02);
    phase("R10");
    idle(4);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule